// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block steps the current address and current count of one DMA channel, one step per transfer strobe from the bus cycle logic. The register interface loads a 16-bit base address and a 16-bit base count; the load also copies both into the current registers. The count register holds one less than the number of transfers to make. The engine drives a physical transfer address made from an external page value and the 16-bit current address. It raises a one-cycle terminal-count pulse when the count runs out.

Only the 16-bit current address moves, so a transfer wraps inside its page and never crosses a window boundary. That window is 64K bytes in byte mode. In word mode the counter addresses 16-bit words, so the window is 128K bytes. With automatic reload selected, the engine restores both current registers from their base copies at terminal count and keeps running. Without it, the channel masks itself and ignores strobes until software unmasks it. In cascade mode the engine does no counting and only relays a request and its acknowledge between a downstream controller and the host.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the channel is masked, the current count and current address are 0, and the terminal-count pulse is low.
- R2: A load strobe copies the base address and base count into the current registers at the next clock edge. A transfer strobe in the same cycle is not counted.
- R3: Each accepted transfer strobe steps the current address by one: up when the direction input is 0, down when it is 1.
- R4: Each accepted strobe decrements the current count, so a loaded count N gives N+1 transfers. The strobe that moves the count from 0x0000 to 0xFFFF is the terminal transfer. The terminal-count output is high for the one cycle after that clock edge.
- R5: The address wraps within 16 bits (0xFFFF up goes to 0x0000, 0x0000 down goes to 0xFFFF). The page bits of the output never change because of a transfer.
- R6: In byte mode the physical address is {page[7:0], current[15:0]}. In word mode it is {page[7:1], current[15:0], 1'b0}, so page bit 0 is ignored and bit 0 is always 0.
- R7: With automatic reload on, the terminal transfer restores the current address and count from the base values and leaves the channel unmasked.
- R8: With automatic reload off, the terminal transfer sets the mask and leaves the count at 0xFFFF. Later strobes change neither the address nor the count.
- R9: An unmask strobe clears the mask. A terminal transfer at the same edge wins and masks the channel.
- R10: In cascade mode strobes are not counted, the transfer address output is 0, hostReq follows cascReq and cascAck follows hostAck. Outside cascade mode both relay outputs are 0.
- R11: Transfer strobes arriving while the channel is masked leave the current address and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStb | input | 1 | Load base and current address and count |
| baseAddrIn | input | 16 | Base address value to load |
| baseCntIn | input | 16 | Base count value to load (transfers minus one) |
| unmaskStb | input | 1 | Clear the channel mask |
| autoInit | input | 1 | 1: reload from base at terminal count |
| addrDown | input | 1 | 1: address decrements, 0: increments |
| wordMode | input | 1 | 1: 16-bit word transfers, 0: byte transfers |
| cascadeMode | input | 1 | 1: relay request and acknowledge only |
| pageIn | input | 8 | External page value for the upper address bits |
| xferStb | input | 1 | One pulse per completed transfer |
| cascReq | input | 1 | Request from the downstream controller |
| hostAck | input | 1 | Acknowledge from the host |
| xferAddr | output | 24 | Physical transfer address |
| curCount | output | 16 | Current count (remaining transfers minus one) |
| tcPulse | output | 1 | Terminal-count pulse |
| masked | output | 1 | Channel mask state |
| hostReq | output | 1 | Relayed request toward the host |
| cascAck | output | 1 | Relayed acknowledge toward the downstream controller |

## Verification
All registered results, meaning current address, count, mask and terminal-count pulse, are due one clock edge after the strobe that causes them. The bench drives every strobe on a falling edge and samples on the next falling edge, half a cycle after the edge that updates the registers. It counts terminal pulses at that same point after each strobe. The physical address and the cascade relay outputs are combinational, so they are checked a short delay after the input changes, with no clock edge in between.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef struct packed {
    logic load;    // copy base into current
    logic step;    // advance address, decrement count
    logic reload;  // terminal transfer with automatic reload
  } engStrobe_t;
endpackage

// File: rtl/dma_eng_ctl.sv
module dma_eng_ctl
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       unmaskStb,
  input  logic       xferStb,
  input  logic       autoInit,
  input  logic       cascadeMode,
  input  logic       cntZero,
  output engStrobe_t strb,
  output logic       masked,
  output logic       tcPulse
);
  logic accept;
  logic lastXfer;

  assign accept   = xferStb & ~masked & ~cascadeMode & ~loadStb;
  assign lastXfer = accept & cntZero;

  always_comb begin
    strb.load   = loadStb;
    strb.step   = accept & ~(cntZero & autoInit);
    strb.reload = lastXfer & autoInit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masked  <= 1'b1;
      tcPulse <= 1'b0;
    end else begin
      tcPulse <= lastXfer;
      if (lastXfer && !autoInit) masked <= 1'b1;
      else if (unmaskStb)        masked <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_eng_dp.sv
module dma_eng_dp
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strb,
  input  logic [ADDR_W-1:0] baseAddrIn,
  input  logic [ADDR_W-1:0] baseCntIn,
  input  logic              addrDown,
  input  logic              wordMode,
  input  logic              cascadeMode,
  input  logic [PAGE_W-1:0] pageIn,
  output logic [ADDR_W-1:0] curCount,
  output logic              cntZero,
  output logic [PHYS_W-1:0] xferAddr
);
  logic [ADDR_W-1:0] baseAddr, baseCnt, curAddr;
  logic [ADDR_W-1:0] addrStep;

  assign addrStep = addrDown ? curAddr - 1'b1 : curAddr + 1'b1;
  assign cntZero  = (curCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      baseCnt  <= '0;
      curAddr  <= '0;
      curCount <= '0;
    end else if (strb.load) begin
      baseAddr <= baseAddrIn;
      baseCnt  <= baseCntIn;
      curAddr  <= baseAddrIn;
      curCount <= baseCntIn;
    end else if (strb.reload) begin
      curAddr  <= baseAddr;
      curCount <= baseCnt;
    end else if (strb.step) begin
      curAddr  <= addrStep;
      curCount <= curCount - 1'b1;
    end
  end

  always_comb begin
    if (cascadeMode)   xferAddr = '0;
    else if (wordMode) xferAddr = {pageIn[PAGE_W-1:1], curAddr, 1'b0};
    else               xferAddr = {pageIn, curAddr};
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [ADDR_W-1:0] baseAddrIn,
  input  logic [ADDR_W-1:0] baseCntIn,
  input  logic              unmaskStb,
  input  logic              autoInit,
  input  logic              addrDown,
  input  logic              wordMode,
  input  logic              cascadeMode,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic              xferStb,
  input  logic              cascReq,
  input  logic              hostAck,
  output logic [PHYS_W-1:0] xferAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic              tcPulse,
  output logic              masked,
  output logic              hostReq,
  output logic              cascAck
);
  engStrobe_t strb;
  logic       cntZero;

  assign hostReq = cascadeMode & cascReq;
  assign cascAck = cascadeMode & hostAck;

  dma_eng_ctl u_ctl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .unmaskStb(unmaskStb),
    .xferStb(xferStb), .autoInit(autoInit), .cascadeMode(cascadeMode),
    .cntZero(cntZero), .strb(strb), .masked(masked), .tcPulse(tcPulse)
  );

  dma_eng_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseAddrIn(baseAddrIn),
    .baseCntIn(baseCntIn), .addrDown(addrDown), .wordMode(wordMode),
    .cascadeMode(cascadeMode), .pageIn(pageIn), .curCount(curCount),
    .cntZero(cntZero), .xferAddr(xferAddr)
  );
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic              autoInit,
  input logic              wordMode,
  input logic              cascadeMode,
  input logic              xferStb,
  input logic [PHYS_W-1:0] xferAddr,
  input logic [ADDR_W-1:0] curCount,
  input logic              tcPulse,
  input logic              masked
);
  // R4: a terminal pulse always follows a strobe
  assert_tc_after_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> $past(xferStb));

  // R8: terminal transfer without reload masks and leaves 0xFFFF
  assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse && !$past(autoInit)) |-> (masked && curCount == '1));

  // R11: masked channel does not count
  assert_masked_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (masked && !loadStb) |=> $stable(curCount));

  // R10: cascade mode neither counts nor drives an address
  assert_cascade_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeMode && !loadStb) |=> $stable(curCount));
  assert_cascade_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    cascadeMode |-> xferAddr == '0);

  // R6: word transfers are always even in bytes
  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordMode |-> !xferAddr[0]);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .autoInit(autoInit),
  .wordMode(wordMode), .cascadeMode(cascadeMode), .xferStb(xferStb),
  .xferAddr(xferAddr), .curCount(curCount), .tcPulse(tcPulse), .masked(masked)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0, unmaskStb = 1'b0, autoInit = 1'b0, addrDown = 1'b0;
  logic        wordMode = 1'b0, cascadeMode = 1'b0, xferStb = 1'b0;
  logic        cascReq = 1'b0, hostAck = 1'b0;
  logic [15:0] baseAddrIn = '0, baseCntIn = '0;
  logic [7:0]  pageIn = '0;
  logic [23:0] xferAddr;
  logic [15:0] curCount;
  logic        tcPulse, masked, hostReq, cascAck;

  int checks = 0;
  int fails  = 0;
  int tcSeen;

  always #2 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .baseAddrIn(baseAddrIn),
    .baseCntIn(baseCntIn), .unmaskStb(unmaskStb), .autoInit(autoInit),
    .addrDown(addrDown), .wordMode(wordMode), .cascadeMode(cascadeMode),
    .pageIn(pageIn), .xferStb(xferStb), .cascReq(cascReq), .hostAck(hostAck),
    .xferAddr(xferAddr), .curCount(curCount), .tcPulse(tcPulse),
    .masked(masked), .hostReq(hostReq), .cascAck(cascAck)
  );

  typedef struct packed {
    logic        dn, wd, ai;
    logic [7:0]  pg;
    logic [15:0] ba, bc;
    logic [7:0]  n;
    logic [23:0] ePhys;
    logic [15:0] eCnt;
    logic [3:0]  eTc;
    logic        eMask;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0,8'h12,16'h1000,16'd3,8'd2,24'h121002,16'd1,4'd0,1'b0}, // R3 R4
    '{1'b0,1'b0,1'b0,8'h12,16'h1000,16'd3,8'd4,24'h121004,16'hFFFF,4'd1,1'b1}, // R4 R8
    '{1'b1,1'b0,1'b0,8'h34,16'h0001,16'd5,8'd3,24'h34FFFE,16'd2,4'd0,1'b0}, // R3 R5
    '{1'b0,1'b1,1'b0,8'h35,16'hFFFE,16'd9,8'd3,24'h340002,16'd6,4'd0,1'b0}, // R5 R6
    '{1'b0,1'b0,1'b1,8'h01,16'h2000,16'd1,8'd2,24'h012000,16'd1,4'd1,1'b0}, // R7
    '{1'b0,1'b0,1'b1,8'h01,16'h2000,16'd1,8'd5,24'h012001,16'd0,4'd2,1'b0}, // R7
    '{1'b0,1'b0,1'b0,8'h00,16'h0100,16'd0,8'd3,24'h000101,16'hFFFF,4'd1,1'b1}, // R8
    '{1'b1,1'b1,1'b1,8'h80,16'h0000,16'd0,8'd1,24'h800000,16'd0,4'd1,1'b0}  // R6 R7
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) xferStb = 1'b1;
    @(negedge clk) xferStb = 1'b0;
    if (tcPulse) tcSeen++;
  endtask

  task automatic loadBase(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk) begin baseAddrIn = a; baseCntIn = c; loadStb = 1'b1; end
    @(negedge clk) loadStb = 1'b0;
  endtask

  task automatic unmask();
    @(negedge clk) unmaskStb = 1'b1;
    @(negedge clk) unmaskStb = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(masked == 1'b1, "R1 mask", masked, 1);
    check(curCount == 16'h0, "R1 count", curCount, 0);
    check(xferAddr == 24'h0, "R1 addr", xferAddr, 0);
    check(tcPulse == 1'b0, "R1 tc", tcPulse, 0);
    @(negedge clk) rstN = 1'b1;

    // R11: strobes while masked are ignored
    loadBase(16'h0500, 16'd4);
    strobe();
    strobe();
    check(curCount == 16'd4, "R11 count", curCount, 4);
    check(xferAddr == 24'h000500, "R11 addr", xferAddr, 24'h000500);

    // R9: unmask clears the mask
    unmask();
    check(masked == 1'b0, "R9 unmask", masked, 0);

    // R2: load wins over a same-cycle strobe
    @(negedge clk) begin
      baseAddrIn = 16'h0700; baseCntIn = 16'd2; loadStb = 1'b1; xferStb = 1'b1;
    end
    @(negedge clk) begin loadStb = 1'b0; xferStb = 1'b0; end
    check(curCount == 16'd2, "R2 count", curCount, 2);
    check(xferAddr == 24'h000700, "R2 addr", xferAddr, 24'h000700);
    check(tcPulse == 1'b0, "R2 tc", tcPulse, 0);

    // R10: cascade relays and does not count
    @(negedge clk) begin cascadeMode = 1'b1; cascReq = 1'b1; hostAck = 1'b0; end
    #1;
    check(hostReq == 1'b1, "R10 req", hostReq, 1);
    check(cascAck == 1'b0, "R10 ack low", cascAck, 0);
    check(xferAddr == 24'h0, "R10 addr", xferAddr, 0);
    @(negedge clk) hostAck = 1'b1;
    #1;
    check(cascAck == 1'b1, "R10 ack", cascAck, 1);
    strobe();
    check(curCount == 16'd2, "R10 count", curCount, 2);
    @(negedge clk) cascadeMode = 1'b0;
    #1;
    check(hostReq == 1'b0 && cascAck == 1'b0, "R10 idle", {hostReq, cascAck}, 0);
    @(negedge clk) begin cascReq = 1'b0; hostAck = 1'b0; end

    // R9: terminal transfer beats a same-edge unmask
    loadBase(16'h0010, 16'd0);
    @(negedge clk) begin xferStb = 1'b1; unmaskStb = 1'b1; end
    @(negedge clk) begin xferStb = 1'b0; unmaskStb = 1'b0; end
    check(masked == 1'b1, "R9 tc wins", masked, 1);
    check(tcPulse == 1'b1, "R4 tc pulse", tcPulse, 1);
    @(negedge clk);
    check(tcPulse == 1'b0, "R4 tc one cycle", tcPulse, 0);

    // table walk
    foreach (VECS[i]) begin
      @(negedge clk) begin
        addrDown = VECS[i].dn; wordMode = VECS[i].wd;
        autoInit = VECS[i].ai; pageIn = VECS[i].pg;
      end
      loadBase(VECS[i].ba, VECS[i].bc);
      unmask();
      tcSeen = 0;
      for (int k = 0; k < int'(VECS[i].n); k++) strobe();
      check(xferAddr == VECS[i].ePhys, $sformatf("R3/R5/R6 vec%0d addr", i),
            xferAddr, VECS[i].ePhys);
      check(curCount == VECS[i].eCnt, $sformatf("R4 vec%0d count", i),
            curCount, VECS[i].eCnt);
      check(tcSeen == int'(VECS[i].eTc), $sformatf("R4/R7 vec%0d tc", i),
            tcSeen, VECS[i].eTc);
      check(masked == VECS[i].eMask, $sformatf("R7/R8 vec%0d mask", i),
            masked, VECS[i].eMask);
    end

    // R5: page bits never change across a wrap
    @(negedge clk) begin addrDown = 1'b0; wordMode = 1'b0; autoInit = 1'b0; pageIn = 8'h5A; end
    loadBase(16'hFFFF, 16'd4);
    unmask();
    strobe();
    check(xferAddr == 24'h5A0000, "R5 wrap", xferAddr, 24'h5A0000);

    finishRun();
  end
endmodule